// File: doc/BRIEF.md
# Indirect Host Parallel Register Port

This block sits on an asynchronous host parallel bus (active-low chip select, write strobe and read strobe, two address lines and a 16-bit data bus) and turns host cycles into single-cycle read and write requests on a simple internal register port. The host never presents a register number on the address lines. It first writes a register number into an index location, and then reads or writes a data location. The index advances by itself after each completed data access, so a run of consecutive registers can be streamed without rewriting it.

A strap input selects a 16-bit or an 8-bit host bus. In 8-bit mode one register takes two host cycles on the low data lines, with the low byte first. The host lines are synchronized into the system clock. An access completes when the deasserting edge of the combined strobe is detected. The strobe is the OR of chip select with write (or read), so either chip select or the write/read line can be the one that pulses.

When the upper address line is low, the port stops decoding. Chip select, write, read, the lower address line and the data lines are then forwarded to a secondary LCD controller bus, and read data from that bus is returned to the host.

Top module: `hpr_port`

## Requirements
- R1: A write with bus_a2=1 and bus_a1=0 loads the index from the low IDX_W data bits. A read of that location returns the index, zero-extended.
- R2: In 16-bit mode (bus_wide=1), a write with bus_a2=1 and bus_a1=1 produces exactly one single-cycle reg_wr pulse after the strobe is released. The pulse carries the full data word and the current index on reg_addr.
- R3: In 16-bit mode, a read of the data location (bus_a2=1, bus_a1=1) issues one single-cycle reg_rd at the current index and drives the returned reg_rdata word on bus_d_out while the read strobe is held.
- R4: After each completed data-location access the index increments by one and wraps from 2^IDX_W-1 to 0. reg_wr and reg_rd are never high together.
- R5: In 8-bit mode (bus_wide=0), the first data write stores the byte on bus_d_in[7:0] as the low byte and makes no reg_wr. The second data write makes one reg_wr of {second byte, first byte} and advances the index.
- R6: In 8-bit mode, the first data read issues one reg_rd and returns the low byte. The second read returns the high byte of the same word without a new reg_rd and advances the index. bus_d_out[15:8] reads as zero.
- R7: An access is accepted whether chip select is held low while the write/read line pulses, or the write/read line is held low while chip select pulses.
- R8: With bus_a2=0, bus_cs_n, bus_wr_n, bus_rd_n, bus_a1 and bus_d_in appear on lcd_cs_n, lcd_wr_n, lcd_rd_n, lcd_a0 and lcd_d_out. During a read, lcd_d_in is returned on bus_d_out. Such cycles leave the index and the register port untouched.
- R9: With bus_a2=1, lcd_cs_n, lcd_wr_n and lcd_rd_n stay high.
- R10: bus_d_oe is low while rst_n is low or bus_cs_n is high, and it is high while bus_cs_n and bus_rd_n are both low after reset.
- R11: In 8-bit mode, an index write cancels a pending low byte, so the next data write is again treated as a low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wide | input | 1 | Strap: 1 selects a 16-bit host bus, 0 an 8-bit bus |
| bus_cs_n | input | 1 | Host chip select, active low |
| bus_wr_n | input | 1 | Host write strobe, active low |
| bus_rd_n | input | 1 | Host read strobe, active low |
| bus_a1 | input | 1 | 0 selects the index location, 1 the data location |
| bus_a2 | input | 1 | 1 selects internal decode, 0 selects LCD forwarding |
| bus_d_in | input | DATA_W | Host data toward the block |
| bus_d_out | output | DATA_W | Data returned to the host |
| bus_d_oe | output | 1 | Enable for the host data drivers |
| lcd_cs_n | output | 1 | Forwarded LCD chip select |
| lcd_wr_n | output | 1 | Forwarded LCD write strobe |
| lcd_rd_n | output | 1 | Forwarded LCD read strobe |
| lcd_a0 | output | 1 | Forwarded LCD command/data select |
| lcd_d_out | output | DATA_W | Forwarded data toward the LCD bus |
| lcd_d_oe | output | 1 | Enable for the LCD data drivers |
| lcd_d_in | input | DATA_W | Data from the LCD bus |
| reg_wr | output | 1 | Single-cycle register write request |
| reg_rd | output | 1 | Single-cycle register read request |
| reg_addr | output | IDX_W | Register number for the request |
| reg_wdata | output | DATA_W | Register write data |
| reg_rdata | input | DATA_W | Register read data, valid in the cycle reg_rd is high |

## Verification
The bench goes after byte-phase handling in 8-bit mode. A design that commits on the first byte, swaps the byte order, or forgets to clear a pending byte on an index write leaves the wrong word in the register model. It checks index wrap at the top register, where a wrong width or a missing increment sends the next access to the wrong register. It drives both strobe styles, because a design that decodes only one of them drops the access. It also runs LCD forwarding cycles between internal accesses, where a port that still decodes would move the index or write a register.

// File: rtl/hpr_pkg.sv
package hpr_pkg;
    // Location selected by the low address line in internal mode
    typedef enum logic {
        LOC_INDEX = 1'b0,
        LOC_DATA  = 1'b1
    } hpr_loc_e;

    // Byte phase of a narrow-bus register access
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } hpr_phase_e;
endpackage

// File: rtl/hpr_sync.sv
module hpr_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[i] <= '0;
                    else        stg_q[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[i] <= '0;
                    else        stg_q[i] <= stg_q[i-1];
                end
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hpr_lcd_fwd.sv
module hpr_lcd_fwd #(
    parameter int DATA_W = 16
) (
    input  logic              fwd_en,
    input  logic              host_cs_n,
    input  logic              host_wr_n,
    input  logic              host_rd_n,
    input  logic              host_a1,
    input  logic [DATA_W-1:0] host_d,
    output logic              lcd_cs_n,
    output logic              lcd_wr_n,
    output logic              lcd_rd_n,
    output logic              lcd_a0,
    output logic [DATA_W-1:0] lcd_d_out,
    output logic              lcd_d_oe
);
    // Transparent path; the LCD side idles high when not forwarding
    always_comb begin
        lcd_cs_n  = fwd_en ? host_cs_n : 1'b1;
        lcd_wr_n  = fwd_en ? host_wr_n : 1'b1;
        lcd_rd_n  = fwd_en ? host_rd_n : 1'b1;
        lcd_a0    = fwd_en ? host_a1   : 1'b0;
        lcd_d_out = fwd_en ? host_d    : '0;
        lcd_d_oe  = fwd_en && !host_cs_n && host_rd_n;
    end
endmodule

// File: rtl/hpr_core.sv
module hpr_core
    import hpr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide,
    input  logic              wr_act_s,
    input  logic              rd_act_s,
    input  logic              a1_s,
    input  logic [DATA_W-1:0] data_s,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [IDX_W-1:0]  reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] rd_word
);
    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  addr;
        hpr_phase_e        phase;
        logic [HALF_W-1:0] lo_byte;
        logic [HALF_W-1:0] hi_hold;
        logic [DATA_W-1:0] snap_data;
        hpr_loc_e          snap_loc;
        logic              wr_prev;
        logic              rd_prev;
        logic              wr;
        logic              rd;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rword;
    } core_st_t;

    core_st_t st_q, st_d;

    logic wr_release;
    logic rd_start;
    logic rd_release;

    always_comb begin
        wr_release = st_q.wr_prev && !wr_act_s;
        rd_start   = rd_act_s && !st_q.rd_prev;
        rd_release = st_q.rd_prev && !rd_act_s;

        st_d         = st_q;
        st_d.wr      = 1'b0;
        st_d.rd      = 1'b0;
        st_d.wr_prev = wr_act_s;
        st_d.rd_prev = rd_act_s;

        // Keep the last bus values seen while the write strobe was active
        if (wr_act_s) begin
            st_d.snap_data = data_s;
            st_d.snap_loc  = hpr_loc_e'(a1_s);
        end

        // Register read data returns in the cycle after the request
        if (st_q.rd) begin
            st_d.rword   = wide ? reg_rdata : {{HALF_W{1'b0}}, reg_rdata[HALF_W-1:0]};
            st_d.hi_hold = reg_rdata[DATA_W-1:HALF_W];
        end

        if (rd_start) begin
            st_d.snap_loc = hpr_loc_e'(a1_s);
            if (hpr_loc_e'(a1_s) == LOC_INDEX) begin
                st_d.rword = DATA_W'(st_q.idx);
            end else if (wide || st_q.phase == PH_LOW) begin
                st_d.rd   = 1'b1;
                st_d.addr = st_q.idx;
            end else begin
                st_d.rword = {{HALF_W{1'b0}}, st_q.hi_hold};
            end
        end

        if (rd_release && st_q.snap_loc == LOC_DATA) begin
            if (wide) begin
                st_d.idx = st_q.idx + IDX_W'(1);
            end else if (st_q.phase == PH_HIGH) begin
                st_d.idx   = st_q.idx + IDX_W'(1);
                st_d.phase = PH_LOW;
            end else begin
                st_d.phase = PH_HIGH;
            end
        end

        if (wr_release) begin
            if (st_q.snap_loc == LOC_INDEX) begin
                st_d.idx   = st_q.snap_data[IDX_W-1:0];
                st_d.phase = PH_LOW;
            end else if (wide) begin
                st_d.wr    = 1'b1;
                st_d.addr  = st_q.idx;
                st_d.wdata = st_q.snap_data;
                st_d.idx   = st_q.idx + IDX_W'(1);
            end else if (st_q.phase == PH_LOW) begin
                st_d.lo_byte = st_q.snap_data[HALF_W-1:0];
                st_d.phase   = PH_HIGH;
            end else begin
                st_d.wr    = 1'b1;
                st_d.addr  = st_q.idx;
                st_d.wdata = {st_q.snap_data[HALF_W-1:0], st_q.lo_byte};
                st_d.idx   = st_q.idx + IDX_W'(1);
                st_d.phase = PH_LOW;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_wr    = st_q.wr;
    assign reg_rd    = st_q.rd;
    assign reg_addr  = st_q.addr;
    assign reg_wdata = st_q.wdata;
    assign rd_word   = st_q.rword;
endmodule

// File: rtl/hpr_port.sv
module hpr_port #(
    parameter int DATA_W      = 16,
    parameter int IDX_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wide,
    input  logic              bus_cs_n,
    input  logic              bus_wr_n,
    input  logic              bus_rd_n,
    input  logic              bus_a1,
    input  logic              bus_a2,
    input  logic [DATA_W-1:0] bus_d_in,
    output logic [DATA_W-1:0] bus_d_out,
    output logic              bus_d_oe,
    output logic              lcd_cs_n,
    output logic              lcd_wr_n,
    output logic              lcd_rd_n,
    output logic              lcd_a0,
    output logic [DATA_W-1:0] lcd_d_out,
    output logic              lcd_d_oe,
    input  logic [DATA_W-1:0] lcd_d_in,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [IDX_W-1:0]  reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int SYNC_W = DATA_W + 3;

    logic              fwd_en;
    logic              wr_act_raw;
    logic              rd_act_raw;
    logic [SYNC_W-1:0] sync_in;
    logic [SYNC_W-1:0] sync_out;
    logic [DATA_W-1:0] rd_word;

    // Combined strobes: whichever of chip select or write/read pulses
    assign fwd_en     = !bus_a2;
    assign wr_act_raw = bus_a2 && !bus_cs_n && !bus_wr_n;
    assign rd_act_raw = bus_a2 && !bus_cs_n && !bus_rd_n;
    assign sync_in    = {wr_act_raw, rd_act_raw, bus_a1, bus_d_in};

    // Strobes, address and data share one pipeline so they stay aligned
    hpr_sync #(
        .W      (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sync_in),
        .q     (sync_out)
    );

    hpr_core #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide      (bus_wide),
        .wr_act_s  (sync_out[SYNC_W-1]),
        .rd_act_s  (sync_out[SYNC_W-2]),
        .a1_s      (sync_out[SYNC_W-3]),
        .data_s    (sync_out[DATA_W-1:0]),
        .reg_rdata (reg_rdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .rd_word   (rd_word)
    );

    hpr_lcd_fwd #(
        .DATA_W (DATA_W)
    ) u_fwd (
        .fwd_en    (fwd_en),
        .host_cs_n (bus_cs_n),
        .host_wr_n (bus_wr_n),
        .host_rd_n (bus_rd_n),
        .host_a1   (bus_a1),
        .host_d    (bus_d_in),
        .lcd_cs_n  (lcd_cs_n),
        .lcd_wr_n  (lcd_wr_n),
        .lcd_rd_n  (lcd_rd_n),
        .lcd_a0    (lcd_a0),
        .lcd_d_out (lcd_d_out),
        .lcd_d_oe  (lcd_d_oe)
    );

    assign bus_d_out = fwd_en ? lcd_d_in : rd_word;
    assign bus_d_oe  = rst_n && !bus_cs_n && !bus_rd_n;
endmodule

// File: rtl/hpr_port_chk.sv
module hpr_port_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_cs_n,
    input logic bus_a2,
    input logic bus_d_oe,
    input logic lcd_cs_n,
    input logic lcd_wr_n,
    input logic lcd_rd_n,
    input logic reg_wr,
    input logic reg_rd
);
    // R10: host data drivers stay off while not selected
    assert_oe_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs_n |-> !bus_d_oe);

    // R9: LCD strobes idle during internal decode
    assert_lcd_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_a2 |-> (lcd_cs_n && lcd_wr_n && lcd_rd_n));

    // R2: a write request lasts one cycle
    assert_wr_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // R3: a read request lasts one cycle
    assert_rd_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    // R4: never a read and a write request together
    assert_req_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));
endmodule

bind hpr_port hpr_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_cs_n (bus_cs_n),
    .bus_a2   (bus_a2),
    .bus_d_oe (bus_d_oe),
    .lcd_cs_n (lcd_cs_n),
    .lcd_wr_n (lcd_wr_n),
    .lcd_rd_n (lcd_rd_n),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd)
);

// File: tb/hpr_port_tb.sv
module hpr_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int IW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wide = 1'b1;
    logic          bus_cs_n = 1'b1;
    logic          bus_wr_n = 1'b1;
    logic          bus_rd_n = 1'b1;
    logic          bus_a1 = 1'b0;
    logic          bus_a2 = 1'b1;
    logic [DW-1:0] bus_d_in = '0;
    logic [DW-1:0] bus_d_out;
    logic          bus_d_oe;
    logic          lcd_cs_n, lcd_wr_n, lcd_rd_n, lcd_a0, lcd_d_oe;
    logic [DW-1:0] lcd_d_out;
    logic [DW-1:0] lcd_d_in = '0;
    logic          reg_wr, reg_rd;
    logic [IW-1:0] reg_addr;
    logic [DW-1:0] reg_wdata;
    logic [DW-1:0] reg_rdata;

    logic [DW-1:0] regs [1 << IW];
    logic [DW-1:0] exp_regs [1 << IW];
    int wr_cnt = 0;
    int rd_cnt = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hpr_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wide(bus_wide),
        .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n),
        .bus_a1(bus_a1), .bus_a2(bus_a2), .bus_d_in(bus_d_in),
        .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe),
        .lcd_cs_n(lcd_cs_n), .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n),
        .lcd_a0(lcd_a0), .lcd_d_out(lcd_d_out), .lcd_d_oe(lcd_d_oe),
        .lcd_d_in(lcd_d_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // Register file model answering the internal port
    assign reg_rdata = regs[reg_addr];
    always @(posedge clk) begin
        if (rst_n && reg_wr) begin
            regs[reg_addr] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (rst_n && reg_rd) rd_cnt <= rd_cnt + 1;
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One internal host cycle; cs_strobe picks which line pulses
    task automatic host_cycle(input bit is_rd, input bit a1, input logic [DW-1:0] d,
                              input bit cs_strobe, output logic [DW-1:0] q);
        @(negedge clk);
        bus_a2 = 1'b1;
        bus_a1 = a1;
        bus_d_in = d;
        if (cs_strobe) begin
            if (is_rd) bus_rd_n = 1'b0; else bus_wr_n = 1'b0;
            @(negedge clk);
            bus_cs_n = 1'b0;
        end else begin
            bus_cs_n = 1'b0;
            @(negedge clk);
            if (is_rd) bus_rd_n = 1'b0; else bus_wr_n = 1'b0;
        end
        repeat (10) @(negedge clk);
        q = bus_d_out;
        if (cs_strobe) begin
            bus_cs_n = 1'b1;
            @(negedge clk);
            bus_rd_n = 1'b1;
            bus_wr_n = 1'b1;
        end else begin
            bus_rd_n = 1'b1;
            bus_wr_n = 1'b1;
            @(negedge clk);
            bus_cs_n = 1'b1;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic wr(input bit a1, input logic [DW-1:0] d, input bit cs_strobe);
        logic [DW-1:0] dummy;
        host_cycle(1'b0, a1, d, cs_strobe, dummy);
    endtask

    task automatic rd(input bit a1, input bit cs_strobe, output logic [DW-1:0] q);
        host_cycle(1'b1, a1, '0, cs_strobe, q);
    endtask

    function automatic logic [DW-1:0] lo_of(input logic [DW-1:0] w);
        return {8'h00, w[7:0]};
    endfunction

    function automatic logic [DW-1:0] hi_of(input logic [DW-1:0] w);
        return {8'h00, w[15:8]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] q;
        int c0;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < (1 << IW); i++) begin
            regs[i] = '0;
            exp_regs[i] = '0;
        end

        // Reset: drivers off even with a read pending (R10)
        bus_cs_n = 1'b0;
        bus_rd_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 oe in reset", bus_d_oe, 1'b0);
        check("R9 lcd idle in reset", {lcd_cs_n, lcd_wr_n, lcd_rd_n}, 3'b111);
        bus_cs_n = 1'b1;
        bus_rd_n = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R2 no write after reset", wr_cnt, 0);

        // Wide mode, both strobe styles (R7)
        bus_wide = 1'b1;
        wr(1'b0, 16'h0010, 1'b0);
        c0 = wr_cnt;
        wr(1'b1, 16'h1234, 1'b1);
        check("R2 one write pulse", wr_cnt - c0, 1);
        check("R7 cs-strobe write", regs[8'h10], 16'h1234);
        rd(1'b0, 1'b0, q);
        check("R1 index readback", q, 16'h0011);
        check("R4 increment after write", q, 16'h0011);
        wr(1'b1, 16'h5678, 1'b0);
        check("R7 wr-strobe write", regs[8'h11], 16'h5678);
        wr(1'b0, 16'h0010, 1'b1);
        c0 = rd_cnt;
        rd(1'b1, 1'b1, q);
        check("R3 data read", q, 16'h1234);
        check("R3 one read request", rd_cnt - c0, 1);
        rd(1'b1, 1'b0, q);
        check("R4 read increments", q, 16'h5678);

        // Index wrap (R4)
        wr(1'b0, 16'h00FF, 1'b0);
        wr(1'b1, 16'hAAAA, 1'b0);
        check("R2 top register", regs[8'hFF], 16'hAAAA);
        rd(1'b0, 1'b0, q);
        check("R4 index wraps", q, 16'h0000);

        // LCD side quiet during an internal read (R9)
        @(negedge clk);
        bus_a2 = 1'b1; bus_a1 = 1'b1; bus_cs_n = 1'b0; bus_rd_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 lcd idle internal", {lcd_cs_n, lcd_wr_n, lcd_rd_n}, 3'b111);
        check("R10 oe during read", bus_d_oe, 1'b1);
        bus_cs_n = 1'b1; bus_rd_n = 1'b1;
        repeat (10) @(negedge clk);
        // that read of register 0 advanced the index to 1
        wr(1'b0, 16'h0010, 1'b0);

        // Narrow mode writes (R5)
        bus_wide = 1'b0;
        wr(1'b0, 16'h0020, 1'b0);
        c0 = wr_cnt;
        wr(1'b1, 16'hFF34, 1'b0);
        check("R5 no write on low byte", wr_cnt - c0, 0);
        wr(1'b1, 16'hEE12, 1'b1);
        check("R5 one write on high byte", wr_cnt - c0, 1);
        check("R5 assembled word", regs[8'h20], 16'h1234);
        rd(1'b0, 1'b0, q);
        check("R5 index advanced", q, 16'h0021);

        // Narrow mode reads (R6)
        wr(1'b0, 16'h0020, 1'b0);
        c0 = rd_cnt;
        rd(1'b1, 1'b0, q);
        check("R6 low byte", q, 16'h0034);
        rd(1'b1, 1'b1, q);
        check("R6 high byte", q, 16'h0012);
        check("R6 single read request", rd_cnt - c0, 1);
        rd(1'b0, 1'b0, q);
        check("R6 index advanced", q, 16'h0021);

        // Index write cancels a pending byte (R11)
        wr(1'b0, 16'h0030, 1'b0);
        wr(1'b1, 16'h00CD, 1'b0);
        wr(1'b0, 16'h0030, 1'b0);
        wr(1'b1, 16'h00EF, 1'b0);
        wr(1'b1, 16'h0001, 1'b0);
        check("R11 phase cleared", regs[8'h30], 16'h01EF);

        // LCD forwarding (R8)
        bus_wide = 1'b1;
        wr(1'b0, 16'h0040, 1'b0);
        c0 = wr_cnt;
        @(negedge clk);
        bus_a2 = 1'b0; bus_a1 = 1'b1; bus_d_in = 16'hBEEF;
        bus_cs_n = 1'b0; bus_wr_n = 1'b0;
        @(negedge clk);
        check("R8 forward write", {lcd_cs_n, lcd_wr_n, lcd_rd_n, lcd_a0, lcd_d_oe}, 5'b00111);
        check("R8 forward data", lcd_d_out, 16'hBEEF);
        repeat (6) @(negedge clk);
        bus_wr_n = 1'b1; bus_cs_n = 1'b1;
        @(negedge clk);
        lcd_d_in = 16'h5A5A; bus_a1 = 1'b0;
        bus_cs_n = 1'b0; bus_rd_n = 1'b0;
        @(negedge clk);
        check("R8 forward read", {bus_d_out, bus_d_oe, lcd_rd_n, lcd_a0}, {16'h5A5A, 3'b100});
        repeat (6) @(negedge clk);
        bus_rd_n = 1'b1; bus_cs_n = 1'b1;
        repeat (8) @(negedge clk);
        check("R8 no register write", wr_cnt - c0, 0);
        rd(1'b0, 1'b0, q);
        check("R8 index untouched", q, 16'h0040);

        // Random traffic: write in one width, read back in another
        for (int i = 0; i < 200; i++) exp_regs[i] = regs[i];
        for (int n = 0; n < 40; n++) begin
            logic [IW-1:0] a;
            logic [DW-1:0] d;
            bit ww, wrd, st;
            a   = IW'($urandom_range(0, 255));
            d   = DW'($urandom);
            ww  = 1'($urandom);
            wrd = 1'($urandom);
            st  = 1'($urandom);
            bus_wide = ww;
            wr(1'b0, DW'(a), st);
            if (ww) begin
                wr(1'b1, d, st);
            end else begin
                wr(1'b1, lo_of(d), st);
                wr(1'b1, hi_of(d), !st);
            end
            bus_wide = wrd;
            wr(1'b0, DW'(a), !st);
            if (wrd) begin
                rd(1'b1, st, q);
                check("R3 random read", q, d);
            end else begin
                rd(1'b1, st, q);
                check("R6 random low", q, lo_of(d));
                rd(1'b1, !st, q);
                check("R6 random high", q, hi_of(d));
            end
            rd(1'b0, st, q);
            check("R4 random index", q, DW'(IW'(a + 1)));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule